// File: doc/BRIEF.md
# Piecewise-Linear Quadratic Spiking Soma

This block is the soma stage at the end of a bit-serial neuron chain. It holds a 16-bit two's-complement membrane potential `u`. Once per update period it sends `u` up the chain as a framed serial packet. The synapse stages add their currents to that value and return it as `u + I` on the downstream line. The soma then adds two shift-and-add correction terms taken from a V-shaped function of the old `u`. The result bends the straight leaky update into a curve close to a quadratic, and the curve's shape is set by a small table of shift amounts and signs, one entry per tap and per region of `u`.

If the result runs past the positive end of the 16-bit range, the block fires a one-clock spike and stores the value with its sign bit forced back to positive. The next accepted update is refractory: it stores a programmable reset potential in place of the computed value. A synchronous write port loads the table and the reset potential.

Both serial lines carry one bit per clock. A packet is a start bit of 1 followed by 16 data bits, least significant bit first. The chain has no valid/ready handshake and cannot stall. The start bit is the only valid marker, and there is no back-pressure in either direction. A returning packet must start inside a fixed window of each period, or the update is skipped and flagged.

Top module: `pwq_soma`

## Requirements
- R1: After reset, `u` equals the parameter INIT_U, no refractory update is pending, every table entry is zero and the reset potential equals the parameter RESET_U. While reset is held, `spike_o` and `miss_o` are low.
- R2: The update period is T = 2·NSYN + 18 clocks, counted 0 to T−1 starting at the end of reset. `up_o` is 1 at count 0, carries bit k−1 of `u` at count k for k = 1..16, and is 0 at every other count.
- R3: While idle, a 1 on `dn_i` at a count c with 1 ≤ c ≤ T−19 starts a packet. The next 16 clocks deliver the value X = u+I, least significant bit first. A 1 on `dn_i` at any other count while idle, or after the 16 data bits, is ignored.
- R4: V(u) is the 16-bit value formed by replacing bit 15 and bit 14 of `u` with the inverse of bit 14, with bits 13..0 kept.
- R5: Table entry {tap, u[15], u[14]} (3-bit index, tap 0 or 1) controls tap `tap`. Bits [3:0] of the entry give an arithmetic right shift p of V(u), and bit 4 set means the shifted value is subtracted instead of added.
- R6: An accepted packet computes W = X + term0 + term1 in full precision, with both terms taken from the old `u`. If −32768 ≤ W ≤ 32767, `u` becomes W. If W < −32768, `u` becomes −32768.
- R7: If W > 32767, `spike_o` is high for exactly one clock, at count c+18. `u` becomes W with bit 15 cleared and bits 14..0 kept, and the next accepted update is marked refractory.
- R8: A refractory accepted update stores the reset potential in `u`, raises no spike and clears the refractory mark.
- R9: If no packet has started by count T−18, `miss_o` is high for one clock at that count, and `u` and the refractory mark are unchanged.
- R10: With `cfg_we` high, address 0..7 writes `cfg_wdata[4:0]` to table entry `cfg_addr`, and address 8 writes the reset potential. Any other address changes nothing. A write completed before count c+17 affects that period's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 4 | Parameter address: 0..7 table, 8 reset potential |
| cfg_wdata | input | 16 | Parameter write data |
| dn_i | input | 1 | Downstream serial input carrying u+I |
| up_o | output | 1 | Upstream serial output carrying u |
| spike_o | output | 1 | One-clock axon pulse |
| miss_o | output | 1 | One-clock flag: no packet arrived in the window |

## Verification
Any wrong value left in the membrane register shows up in the next upstream packet, at most T clocks after the faulty update. Every update is therefore checked one period later against an arithmetic model of the tap equation. A wrong table index or shift shows the same way, provided the sweep drives `u` into every region with different table contents. A lost or stuck refractory mark changes the value stored on the following accepted update, and also whether a spike pulse appears in the period after a spike, so it is caught within two periods, including when a missed packet comes between them. A wrong acceptance window shows at once as a `miss_o` pulse, or its absence, at count T−18, and for the packets at counts 19 and 20 it shows exactly at that boundary.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
  localparam int SHW = 4;          // shift field, covers shifts 0..15
  localparam int NTAP = 2;
  localparam int NREG = 4;         // regions from sign and top magnitude bit
  localparam int NENT = NTAP * NREG;

  typedef struct packed {
    logic           sub;
    logic [SHW-1:0] sh;
  } tap_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_DATA,
    RX_TAP1,
    RX_TAP2,
    RX_DONE
  } rx_st_t;
endpackage

// File: rtl/pwq_cfg_regs.sv
module pwq_cfg_regs
  import pwq_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] RESET_U = 16'hC000,
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output tap_cfg_t       tab_o [NENT],
  output logic [DW-1:0]  rpot_o
);
  localparam int CFGW = $bits(tap_cfg_t);

  tap_cfg_t      tab_q [NENT];
  logic [DW-1:0] rpot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) tab_q[e] <= '0;
      rpot_q <= RESET_U;
    end else if (we_i) begin
      for (int e = 0; e < NENT; e++)
        if (addr_i == AW'(e)) tab_q[e] <= tap_cfg_t'(wdata_i[CFGW-1:0]);
      if (addr_i == AW'(NENT)) rpot_q <= wdata_i;
    end
  end

  assign tab_o  = tab_q;
  assign rpot_o = rpot_q;

  // R10: the reset potential moves only on a write to its own address
  a_r10_rpot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == AW'(NENT)) |=> $stable(rpot_q));
endmodule

// File: rtl/pwq_tap_term.sv
module pwq_tap_term
  import pwq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]        u_i,
  input  tap_cfg_t             cfg_i,
  output logic signed [DW+1:0] term_o
);
  localparam int XW = DW + 2;

  logic signed [DW-1:0] vsh;
  logic signed [DW-1:0] shifted;

  always_comb begin
    vsh     = {~u_i[DW-2], ~u_i[DW-2], u_i[DW-3:0]};
    shifted = vsh >>> cfg_i.sh;
    term_o  = cfg_i.sub ? -XW'(shifted) : XW'(shifted);
  end
endmodule

// File: rtl/pwq_rx.sv
module pwq_rx
  import pwq_pkg::*;
#(
  parameter int DW = 16,
  parameter int PERIOD = 38,
  parameter int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          dn_i,
  output logic [DW-1:0] word_o,
  output logic          tap1_o,
  output logic          tap2_o,
  output logic          miss_o
);
  localparam int IW = $clog2(DW);
  localparam int WIN_LO = 1;
  localparam int WIN_HI = PERIOD - 19;
  localparam int MISS_AT = PERIOD - 18;

  rx_st_t        st_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] word_q;
  logic          in_win;

  assign in_win = (cnt_i >= CW'(WIN_LO)) && (cnt_i <= CW'(WIN_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        RX_IDLE: if (dn_i && in_win) begin
          st_q  <= RX_DATA;
          idx_q <= '0;
        end
        RX_DATA: begin
          word_q[idx_q] <= dn_i;
          idx_q         <= idx_q + IW'(1);
          if (idx_q == IW'(DW - 1)) st_q <= RX_TAP1;
        end
        RX_TAP1: st_q <= RX_TAP2;
        RX_TAP2: st_q <= (cnt_i == CW'(PERIOD - 1)) ? RX_IDLE : RX_DONE;
        RX_DONE: if (cnt_i == CW'(PERIOD - 1)) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign word_o = word_q;
  assign tap1_o = (st_q == RX_TAP1);
  assign tap2_o = (st_q == RX_TAP2);
  assign miss_o = (st_q == RX_IDLE) && (cnt_i == CW'(MISS_AT));

  // R3: a packet only opens on a start bit seen inside the window
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DATA && $past(st_q) == RX_IDLE) |->
      ($past(cnt_i) >= CW'(WIN_LO) && $past(cnt_i) <= CW'(WIN_HI)));

  // R3: every period starts with the receiver idle
  a_r3_idle_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == CW'(PERIOD - 1)) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/pwq_soma.sv
module pwq_soma
  import pwq_pkg::*;
#(
  parameter int DW = 16,
  parameter int NSYN = 10,
  parameter logic [DW-1:0] INIT_U = 16'hC000,
  parameter logic [DW-1:0] RESET_U = 16'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          dn_i,
  output logic          up_o,
  output logic          spike_o,
  output logic          miss_o
);
  localparam int PERIOD = 2 * NSYN + 18;
  localparam int CW = $clog2(PERIOD);
  localparam int IW = $clog2(DW);
  localparam int XW = DW + 2;

  logic [CW-1:0]        cnt_q;
  logic [DW-1:0]        u_q;
  logic                 refr_q;
  logic signed [XW-1:0] part_q;
  tap_cfg_t             tab [NENT];
  logic [DW-1:0]        rpot;
  logic [DW-1:0]        rx_word;
  logic                 tap1, tap2;
  logic signed [XW-1:0] term [NTAP];
  logic signed [XW-1:0] wide2;
  logic                 pos_ovf, neg_ovf;

  // period counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end

  // upstream serializer reads the held potential directly
  always_comb begin
    up_o = 1'b0;
    if (cnt_q == '0) up_o = 1'b1;
    else if (cnt_q <= CW'(DW)) up_o = u_q[IW'(cnt_q - CW'(1))];
  end

  pwq_cfg_regs #(.DW(DW), .RESET_U(RESET_U), .AW(4)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .tab_o   (tab),
    .rpot_o  (rpot)
  );

  pwq_rx #(.DW(DW), .PERIOD(PERIOD), .CW(CW)) rx_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_q),
    .dn_i   (dn_i),
    .word_o (rx_word),
    .tap1_o (tap1),
    .tap2_o (tap2),
    .miss_o (miss_o)
  );

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    logic [2:0] sel;
    assign sel = {1'(t), u_q[DW-1], u_q[DW-2]};
    pwq_tap_term #(.DW(DW)) term_i (
      .u_i    (u_q),
      .cfg_i  (tab[sel]),
      .term_o (term[t])
    );
  end

  assign wide2   = part_q + term[1];
  assign pos_ovf = !wide2[XW-1] && (|wide2[XW-2:DW-1]);
  assign neg_ovf = wide2[XW-1] && !(&wide2[XW-2:DW-1]);
  assign spike_o = tap2 && !refr_q && pos_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q    <= INIT_U;
      refr_q <= 1'b0;
      part_q <= '0;
    end else begin
      if (tap1) part_q <= XW'($signed(rx_word)) + term[0];
      if (tap2) begin
        if (refr_q) begin
          u_q    <= rpot;
          refr_q <= 1'b0;
        end else if (pos_ovf) begin
          u_q    <= {1'b0, wide2[DW-2:0]};
          refr_q <= 1'b1;
        end else if (neg_ovf) begin
          u_q <= {1'b1, {(DW-1){1'b0}}};
        end else begin
          u_q <= wide2[DW-1:0];
        end
      end
    end
  end

  // R8: refractory update loads the reset potential and clears the mark
  a_r8_refr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tap2 && refr_q) |=> (u_q == $past(rpot) && !refr_q));

  // R7: after a spike the stored value is positive and refractory is pending
  a_r7_sign_fix: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |=> (!u_q[DW-1] && refr_q));

  // R9: a missed packet leaves potential and refractory mark alone
  a_r9_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> ($stable(u_q) && $stable(refr_q)));

  // R2: the potential never changes while it is being sent upstream
  a_r2_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && cnt_q <= CW'(DW)) |-> $stable(u_q));
endmodule

// File: tb/pwq_soma_tb_top.sv
module pwq_soma_tb_top;
  localparam int NSYN = 10;
  localparam int PERIOD = 2 * NSYN + 18;
  localparam int WIN_HI = PERIOD - 19;
  localparam logic [15:0] INIT_U = 16'hC000;
  localparam logic [15:0] RESET_U = 16'hC000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        dn_i = 1'b0;
  logic        up_o, spike_o, miss_o;

  always #4 clk = ~clk;

  pwq_soma #(.DW(16), .NSYN(NSYN), .INIT_U(INIT_U), .RESET_U(RESET_U)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dn_i(dn_i), .up_o(up_o), .spike_o(spike_o),
    .miss_o(miss_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0]  tab_m [8];
  logic [15:0] rpot_m;
  logic [15:0] u_m;
  bit          refr_m;
  bit          dirty;
  string       prev_tag;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // tap term from the requirement: V(u) shifted and signed per table entry
  function automatic int term_of(input logic [15:0] u, input int t);
    logic [15:0] v;
    int vi, idx, sh;
    v   = {~u[14], ~u[14], u[13:0]};
    vi  = $signed(v);
    idx = t * 4 + int'(u[15:14]);
    sh  = vi >>> tab_m[idx][3:0];
    return tab_m[idx][4] ? -sh : sh;
  endfunction

  function automatic logic [15:0] next_rand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf;
  endfunction

  // one full period, starting at the negedge of count 0
  task automatic do_period(input logic [15:0] ival, input int dly);
    logic [15:0] cap, x, u_exp, u_new;
    int nsp, nmiss, nloud, w;
    bit acc, exp_spk, r_new, was_dirty;
    string new_tag;
    u_exp = u_m;
    x = u_m + ival;
    acc = (dly >= 1 && dly <= WIN_HI);
    exp_spk = 0; u_new = u_m; r_new = refr_m; new_tag = "R9 hold";
    was_dirty = dirty;
    if (acc) begin
      if (refr_m) begin
        u_new = rpot_m; r_new = 0; new_tag = "R8 reset load";
      end else begin
        w = $signed(x) + term_of(u_m, 0) + term_of(u_m, 1);
        if (w > 32767) begin
          u_new = {1'b0, w[14:0]}; r_new = 1; exp_spk = 1; new_tag = "R7 sign fix";
        end else if (w < -32768) begin
          u_new = 16'h8000; new_tag = "R6 clamp";
        end else begin
          u_new = w[15:0]; new_tag = "R4/R5/R6 update";
        end
      end
    end
    if (was_dirty) new_tag = {new_tag, " R10"};
    chk(up_o === 1'b1, "R2 start bit", int'(up_o), 1);
    cap = '0; nsp = 0; nmiss = 0; nloud = 0;
    for (int k = 1; k < PERIOD; k++) begin
      @(negedge clk);
      if (k <= 16) cap[k-1] = up_o;
      else if (up_o !== 1'b0) nloud++;
      cfg_we = 1'b0;
      if (was_dirty) begin
        if (k <= 8) begin
          cfg_we = 1'b1; cfg_addr = 4'(k - 1); cfg_wdata = {11'b0, tab_m[k-1]};
        end else if (k == 9) begin
          cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = rpot_m;
        end else if (k == 10) begin
          cfg_we = 1'b1; cfg_addr = 4'd12; cfg_wdata = 16'hFFFF;  // R10 ignored address
        end
      end
      dn_i = 1'b0;
      if (dly > 0) begin
        if (k == dly) dn_i = 1'b1;
        else if (k > dly && k <= dly + 16) dn_i = x[k-dly-1];
        else if (k == dly + 17) dn_i = 1'b1;  // R3 stray bit after the packet
      end
      if (spike_o === 1'b1) nsp++;
      if (miss_o === 1'b1) nmiss++;
    end
    @(negedge clk);
    dn_i = 1'b0; cfg_we = 1'b0; dirty = 0;
    chk(cap == u_exp, prev_tag, int'(cap), int'(u_exp));
    chk(nloud == 0, "R2 idle upstream line", nloud, 0);
    chk(nsp == int'(exp_spk), "R7 spike pulse", nsp, int'(exp_spk));
    chk(nmiss == (acc ? 0 : 1), "R3/R9 window and miss pulse", nmiss, acc ? 0 : 1);
    u_m = u_new; refr_m = r_new; prev_tag = new_tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 8; e++) tab_m[e] = '0;
    rpot_m = RESET_U; u_m = INIT_U; refr_m = 0; dirty = 0; prev_tag = "R1 reset value";
    repeat (3) @(negedge clk);
    chk(spike_o === 1'b0, "R1 spike low in reset", int'(spike_o), 0);
    chk(miss_o === 1'b0, "R1 miss low in reset", int'(miss_o), 0);
    rst_n = 1'b1;  // this negedge is inside count 0

    do_period(16'h0000, 17);

    // sweep table contents, reset potentials, packet delays and values
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 8; e++)
        tab_m[e] = {1'((c >> (e % 4)) & 1), 4'((c + 3 * e) % 16)};
      rpot_m = 16'(c * 4099 - 20000);
      dirty = 1;
      for (int p = 0; p < 12; p++) begin
        logic [15:0] iv;
        iv = next_rand();
        if (p % 4 == 3) iv = 16'h7F00 - u_m;
        do_period(iv, 17 + (p % 3));
      end
    end

    // force a spike, miss a period, then the refractory load
    for (int e = 0; e < 8; e++) tab_m[e] = 5'h01;
    rpot_m = 16'hE123;
    dirty = 1;
    for (int n = 0; n < 5; n++) begin
      do_period(16'h7FFF - u_m, 18);
      if (refr_m) break;
    end
    chk(refr_m == 1'b1, "R7 spike reached", int'(refr_m), 1);
    do_period(16'h1111, 0);    // no packet at all
    do_period(16'h2222, 20);   // first count past the window
    do_period(16'h1234, 19);   // last count in the window, refractory
    do_period(16'h0100, 17);
    do_period(16'h0000, 17);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule